// File: doc/BRIEF.md
# Dual-Port Video Memory with Row Transfer

This block models a video memory with two ways in. The random-access port works like a multiplexed-address DRAM. A row address is taken when the row strobe falls, and a column address is taken when the column strobe falls. The write-enable level at that column strobe picks a read or a write. The second port is a serial output fed from an internal line buffer that holds one whole memory row. The line buffer is loaded by a transfer cycle, and a serial clock then streams it out one word per rising edge.

The level of the combined transfer/output-enable control at the falling row strobe decides what kind of cycle follows. If the control is active, the cycle is a row-to-buffer transfer. The column address of that cycle gives the first buffer position to stream. If the control is inactive, the cycle is an ordinary access, and during reads the same pin gates the data bus driver. All strobes and the serial clock are sampled on the system clock, and their edges are found by comparing each sample with the one before it. The array depth is a parameter, and each row is as wide as the line buffer.

Top module: `vram_dual_port`

## Requirements
- R1: When `dtoe_n` is low (active) at the sampled falling edge of `ras_n`, the cycle is a transfer: its column strobe does not write the array, and `dq` is never driven during it.
- R2: In a transfer cycle, the clock after the falling `cas_n` is sampled copies the row latched at `ras_n` (row index = `addr` modulo `ROWS`) into the line buffer, and sets the serial pointer to the column latched at `cas_n`.
- R3: Each sampled rising edge of `sclk` updates `sq` to the buffer word at the serial pointer, then advances the pointer by one. The pointer wraps from `COLS-1` (255) to 0.
- R4: In a normal cycle (`dtoe_n` high at the falling `ras_n`), a falling `cas_n` with `we_n` low writes the value on `dq` into the latched row at column `addr`.
- R5: In a normal cycle, a falling `cas_n` with `we_n` high reads the addressed word. It is driven on `dq` from the clock after that edge, for as long as `cas_n`, `ras_n` and `dtoe_n` stay low.
- R6: During a normal read, `dtoe_n` high keeps `dq` in high impedance.
- R7: Reset (`rst_n` low) clears the serial pointer, `sq`, and the latched row and column, and releases `dq`. The line buffer contents survive reset.
- R8: A rising `sclk` sampled on the same clock as a transfer load is dropped: `sq` holds, and the pointer takes the transfer column.
- R9: A falling `cas_n` while `ras_n` is high has no effect on the array.
- R10: Between sampled rising edges of `sclk`, `sq` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (8) | Multiplexed address: row at `ras_n` fall, column at `cas_n` fall |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low, sampled at the `cas_n` fall |
| dtoe_n | input | 1 | Transfer select at the `ras_n` fall; read output enable afterwards; active low |
| dq | inout | DATA_W (16) | Random-access data bus |
| sclk | input | 1 | Serial clock, rising edges sampled on `clk` |
| sq | output | DATA_W (16) | Serial data output |

## Verification
The hardest case to reach is a serial clock edge that lands exactly on the clock where the transfer load happens. That edge must be dropped while the pointer jumps to the transfer column. The stimulus raises `sclk` one clock after the column strobe falls, so the edge is sampled on the load clock. The bench also drives junk data with `we_n` low during transfer cycles and stray column strobes, then reads the affected words back to show the array was left unchanged. A reset in the middle of a stream checks that the pointer returns to zero while the buffer keeps its contents.

// File: rtl/vram_pkg.sv
package vram_pkg;

   typedef enum logic [1:0] {
      CYC_IDLE   = 2'd0,
      CYC_ACCESS = 2'd1,
      CYC_XFER   = 2'd2
   } cyc_e;

   function automatic int unsigned idx_w(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/vram_strobe_ctl.sv
module vram_strobe_ctl
   import vram_pkg::*;
#(
   parameter int unsigned ROWS   = 2,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned COL_W  = 8,
   parameter int unsigned ROW_W  = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              dtoe_n,
   output logic [ROW_W-1:0]  row_lat,
   output logic [COL_W-1:0]  col_lat,
   output logic [COL_W-1:0]  col_now,
   output logic              wr_stb,
   output logic              rd_stb,
   output logic              rd_hold,
   output logic              xfer_load,
   output logic              cyc_xfer
);

   logic             ras_q, cas_q;
   logic             ras_fall, cas_fall, col_take;
   logic [ROW_W-1:0] row_next;
   cyc_e             cyc;

   assign ras_fall = ras_q & ~ras_n;
   assign cas_fall = cas_q & ~cas_n;
   assign col_take = cas_fall & ~ras_n & (cyc != CYC_IDLE);
   assign col_now  = addr[COL_W-1:0];
   assign wr_stb   = col_take & (cyc == CYC_ACCESS) & ~we_n;
   assign rd_stb   = col_take & (cyc == CYC_ACCESS) & we_n;
   assign cyc_xfer = (cyc == CYC_XFER);

   generate
      if (ROWS == 1) begin : g_one_row
         assign row_next = '0;
      end else begin : g_multi_row
         assign row_next = addr[ROW_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ras_q     <= 1'b1;
         cas_q     <= 1'b1;
         cyc       <= CYC_IDLE;
         row_lat   <= '0;
         col_lat   <= '0;
         xfer_load <= 1'b0;
         rd_hold   <= 1'b0;
      end else begin
         ras_q     <= ras_n;
         cas_q     <= cas_n;
         xfer_load <= col_take & (cyc == CYC_XFER);
         if (ras_n) begin
            cyc <= CYC_IDLE;
         end else if (ras_fall) begin
            cyc     <= dtoe_n ? CYC_ACCESS : CYC_XFER;
            row_lat <= row_next;
         end
         if (col_take) begin
            col_lat <= col_now;
         end
         if (cas_n || ras_n) begin
            rd_hold <= 1'b0;
         end else if (rd_stb) begin
            rd_hold <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/vram_array.sv
module vram_array #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned COLS   = 256,
   parameter int unsigned ROWS   = 2,
   parameter int unsigned COL_W  = 8,
   parameter int unsigned ROW_W  = 1
) (
   input  logic                        clk,
   input  logic                        wr_en,
   input  logic                        rd_en,
   input  logic [ROW_W-1:0]            row,
   input  logic [COL_W-1:0]            col,
   input  logic [DATA_W-1:0]           wdata,
   output logic [DATA_W-1:0]           rdata,
   output logic [COLS-1:0][DATA_W-1:0] row_words
);

   logic [COLS-1:0][DATA_W-1:0] rows_all [ROWS];

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         logic [COLS-1:0][DATA_W-1:0] cells;
         always_ff @(posedge clk) begin
            if (wr_en && (row == ROW_W'(r))) begin
               cells[col] <= wdata;
            end
         end
         assign rows_all[r] = cells;
      end
   endgenerate

   assign row_words = rows_all[row];

   always_ff @(posedge clk) begin
      if (rd_en) begin
         rdata <= rows_all[row][col];
      end
   end

endmodule

// File: rtl/vram_line_buf.sv
module vram_line_buf #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned COLS   = 256,
   parameter int unsigned COL_W  = 8
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        load,
   input  logic [COLS-1:0][DATA_W-1:0] load_words,
   input  logic [COL_W-1:0]            load_ptr,
   input  logic                        sclk,
   output logic [DATA_W-1:0]           sq,
   output logic [COL_W-1:0]            ptr
);

   logic [COLS-1:0][DATA_W-1:0] lbuf;
   logic                        sclk_q;
   logic                        advance;
   logic [COL_W-1:0]            ptr_inc;

   assign advance = sclk & ~sclk_q & ~load;

   generate
      if ((1 << COL_W) == COLS) begin : g_wrap_free
         assign ptr_inc = ptr + 1'b1;
      end else begin : g_wrap_cmp
         assign ptr_inc = (ptr == COL_W'(COLS - 1)) ? '0 : ptr + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (load) begin
         lbuf <= load_words;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b1;
         ptr    <= '0;
         sq     <= '0;
      end else begin
         sclk_q <= sclk;
         if (load) begin
            ptr <= load_ptr;
         end else if (advance) begin
            sq  <= lbuf[ptr];
            ptr <= ptr_inc;
         end
      end
   end

endmodule

// File: rtl/vram_dual_port.sv
module vram_dual_port
   import vram_pkg::*;
#(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned COLS   = 256,
   parameter int unsigned ROWS   = 2,
   localparam int unsigned COL_W  = idx_w(COLS),
   localparam int unsigned ROW_W  = idx_w(ROWS),
   localparam int unsigned ADDR_W = (COL_W > ROW_W) ? COL_W : ROW_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic              dtoe_n,
   inout  wire  [DATA_W-1:0] dq,
   input  logic              sclk,
   output logic [DATA_W-1:0] sq
);

   initial begin
      if (DATA_W < 1) $fatal(1, "DATA_W must be at least 1");
      if (COLS < 2) $fatal(1, "COLS must be at least 2");
      if (ROWS < 1) $fatal(1, "ROWS must be at least 1");
      if ((ROWS > 1) && ((1 << ROW_W) != ROWS)) $fatal(1, "ROWS must be a power of two");
   end

   logic [ROW_W-1:0]            row_lat;
   logic [COL_W-1:0]            col_lat, col_now, ptr;
   logic                        wr_stb, rd_stb, rd_hold, xfer_load, cyc_xfer;
   logic                        dq_oe;
   logic [DATA_W-1:0]           rdata;
   logic [COLS-1:0][DATA_W-1:0] row_words;

   vram_strobe_ctl #(
      .ROWS(ROWS), .ADDR_W(ADDR_W), .COL_W(COL_W), .ROW_W(ROW_W)
   ) u_ctl (
      .clk(clk), .rst_n(rst_n), .addr(addr),
      .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .dtoe_n(dtoe_n),
      .row_lat(row_lat), .col_lat(col_lat), .col_now(col_now),
      .wr_stb(wr_stb), .rd_stb(rd_stb), .rd_hold(rd_hold),
      .xfer_load(xfer_load), .cyc_xfer(cyc_xfer)
   );

   vram_array #(
      .DATA_W(DATA_W), .COLS(COLS), .ROWS(ROWS), .COL_W(COL_W), .ROW_W(ROW_W)
   ) u_array (
      .clk(clk), .wr_en(wr_stb), .rd_en(rd_stb),
      .row(row_lat), .col(col_now), .wdata(dq),
      .rdata(rdata), .row_words(row_words)
   );

   vram_line_buf #(
      .DATA_W(DATA_W), .COLS(COLS), .COL_W(COL_W)
   ) u_lbuf (
      .clk(clk), .rst_n(rst_n), .load(xfer_load),
      .load_words(row_words), .load_ptr(col_lat),
      .sclk(sclk), .sq(sq), .ptr(ptr)
   );

   assign dq_oe = rd_hold & ~cas_n & ~ras_n & we_n & ~dtoe_n;
   assign dq    = dq_oe ? rdata : {DATA_W{1'bz}};

endmodule

// File: rtl/vram_dual_port_chk.sv
module vram_dual_port_chk #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned COL_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ras_n,
   input logic              cas_n,
   input logic              dtoe_n,
   input logic              sclk,
   input logic [DATA_W-1:0] sq,
   input logic              dq_oe,
   input logic              cyc_xfer,
   input logic              xfer_load,
   input logic [COL_W-1:0]  ptr
);

   logic sclk_d;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_d <= 1'b1;
      else        sclk_d <= sclk;
   end

   assert_reset_clears_R7: assert property (@(posedge clk)
      !rst_n |=> (ptr == '0 && sq == '0 && !dq_oe));

   assert_xfer_never_drives_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cyc_xfer |-> !dq_oe);

   assert_load_after_cas_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n) && !ras_n && cyc_xfer) |=> xfer_load);

   assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && !sclk_d && !xfer_load) |=> (ptr == COL_W'($past(ptr) + 1'b1)));

   assert_drive_after_cas_R5: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> $past(!cas_n));

   assert_oe_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dtoe_n |-> !dq_oe);

   assert_load_drops_sclk_R8: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_load |=> $stable(sq));

   assert_sq_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !(sclk && !sclk_d) |=> $stable(sq));

endmodule

bind vram_dual_port vram_dual_port_chk #(.DATA_W(DATA_W), .COL_W(COL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .dtoe_n(dtoe_n),
   .sclk(sclk), .sq(sq), .dq_oe(dq_oe), .cyc_xfer(cyc_xfer),
   .xfer_load(xfer_load), .ptr(ptr)
);

// File: tb/vram_dual_port_tb.sv
`timescale 1ns/1ps
module vram_dual_port_tb;

   localparam int DW   = 16;
   localparam int COLS = 256;
   localparam int ROWS = 2;
   localparam logic [DW-1:0] PULLED = 16'hFFFF;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [7:0]    addr = '0;
   logic          ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, dtoe_n = 1'b1, sclk = 1'b0;
   logic          tb_oe = 1'b0;
   logic [DW-1:0] tb_val = '0;
   wire  [DW-1:0] dq;
   logic [DW-1:0] sq;

   always #2.5 clk = ~clk;

   assign dq = tb_oe ? tb_val : {DW{1'bz}};
   for (genvar i = 0; i < DW; i++) begin : g_pu
      pullup (dq[i]);
   end

   vram_dual_port u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .dtoe_n(dtoe_n), .dq(dq), .sclk(sclk), .sq(sq)
   );

   int    checks = 0, failures = 0;
   bit    done = 1'b0;
   string cur_req = "R7";

   // reference model
   int          m_mem [ROWS*COLS];
   int          m_buf [COLS];
   int          m_ptr, m_row, m_col, m_mode, m_rdv;
   bit          m_pend, m_rd, m_ras_p, m_cas_p, m_sclk_p;
   logic [DW-1:0] m_sq;

   always @(posedge clk) begin
      bit ras_f, cas_f, sck_r, take;
      if (!rst_n) begin
         m_ptr = 0; m_row = 0; m_col = 0; m_mode = 0; m_pend = 0; m_rd = 0;
         m_sq = '0; m_ras_p = 1; m_cas_p = 1; m_sclk_p = 1;
      end else begin
         ras_f = m_ras_p && !ras_n;
         cas_f = m_cas_p && !cas_n;
         sck_r = !m_sclk_p && sclk;
         take  = cas_f && !ras_n && (m_mode != 0);
         if (m_pend) begin
            for (int i = 0; i < COLS; i++) m_buf[i] = m_mem[m_row*COLS + i];
            m_ptr = m_col;
         end else if (sck_r) begin
            m_sq  = DW'(m_buf[m_ptr]);
            m_ptr = (m_ptr + 1) % COLS;
         end
         m_pend = 0;
         if (take) begin
            m_col = int'(addr);
            if (m_mode == 2) m_pend = 1;
            else if (!we_n) m_mem[m_row*COLS + int'(addr)] = int'(dq);
            else begin m_rd = 1; m_rdv = m_mem[m_row*COLS + int'(addr)]; end
         end
         if (cas_n || ras_n) m_rd = 0;
         if (ras_n) m_mode = 0;
         else if (ras_f) begin
            m_mode = dtoe_n ? 1 : 2;
            m_row  = int'(addr) % ROWS;
         end
         m_ras_p = ras_n; m_cas_p = cas_n; m_sclk_p = sclk;
      end
   end

   function automatic logic [DW-1:0] fill(int r, int c);
      return DW'(16'h1000 * (r + 1) + c * 3);
   endfunction

   task automatic chk(bit ok, string req, logic [DW-1:0] act, logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic tick();
      logic [DW-1:0] exp_dq;
      @(posedge clk);
      #1;
      if (tb_oe) exp_dq = tb_val;
      else if (m_rd && !cas_n && !ras_n && we_n && !dtoe_n) exp_dq = DW'(m_rdv);
      else exp_dq = PULLED;
      if (rst_n) begin
         chk(sq === m_sq, {cur_req, " sq"}, sq, m_sq);
         chk(dq === exp_dq, {cur_req, " dq"}, dq, exp_dq);
      end
   endtask

   task automatic ram_write(int r, int c, logic [DW-1:0] v);
      addr = 8'(r); dtoe_n = 1; ras_n = 0; tick();
      addr = 8'(c); we_n = 0; tb_val = v; tb_oe = 1; cas_n = 0; tick(); tick();
      cas_n = 1; ras_n = 1; we_n = 1; tb_oe = 0; tick();
   endtask

   task automatic ram_read(int r, int c, bit oe_on, logic [DW-1:0] exp, string req);
      addr = 8'(r); dtoe_n = 1; ras_n = 0; tick();
      addr = 8'(c); we_n = 1; cas_n = 0; dtoe_n = oe_on ? 1'b0 : 1'b1; tick();
      chk(dq === (oe_on ? exp : PULLED), req, dq, oe_on ? exp : PULLED);
      tick();
      chk(dq === (oe_on ? exp : PULLED), req, dq, oe_on ? exp : PULLED);
      cas_n = 1; ras_n = 1; dtoe_n = 1; tick();
      chk(dq === PULLED, req, dq, PULLED);
   endtask

   task automatic transfer(int r, int c, bit collide);
      logic [DW-1:0] sq_before;
      addr = 8'(r); dtoe_n = 0; ras_n = 0; tick();
      dtoe_n = 1; addr = 8'(c); cas_n = 0; we_n = 0; tb_val = 16'hDEAD; tb_oe = 1; tick();
      sq_before = sq;
      if (collide) sclk = 1;
      tick();
      if (collide) chk(sq === sq_before, "R8", sq, sq_before);
      sclk = 0; cas_n = 1; ras_n = 1; we_n = 1; tb_oe = 0; tick();
   endtask

   task automatic stream(int n, int r, int c0, string req);
      for (int i = 0; i < n; i++) begin
         sclk = 1; tick();
         chk(sq === fill(r, (c0 + i) % COLS), req, sq, fill(r, (c0 + i) % COLS));
         sclk = 0; tick();
      end
   endtask

   initial begin
      logic [DW-1:0] hold;
      tick(); tick();
      chk(sq === '0, "R7", sq, '0);
      chk(dq === PULLED, "R7", dq, PULLED);
      rst_n = 1; tick();

      cur_req = "R4";
      for (int r = 0; r < ROWS; r++)
         for (int c = 0; c < COLS; c++) ram_write(r, c, fill(r, c));

      cur_req = "R5";
      ram_read(0, 0, 1, fill(0, 0), "R5");
      ram_read(1, 255, 1, fill(1, 255), "R5");
      ram_read(0, 77, 1, fill(0, 77), "R4");
      cur_req = "R6";
      ram_read(1, 12, 0, fill(1, 12), "R6");

      cur_req = "R2";
      transfer(1, 250, 0);
      cur_req = "R3";
      stream(10, 1, 250, "R3");
      cur_req = "R10";
      hold = sq;
      for (int i = 0; i < 5; i++) tick();
      chk(sq === hold, "R10", sq, hold);

      cur_req = "R1";
      ram_read(1, 251, 1, fill(1, 251), "R1");

      cur_req = "R8";
      transfer(0, 40, 1);
      stream(4, 0, 40, "R8");

      cur_req = "R9";
      ras_n = 1; addr = 8'd5; we_n = 0; tb_val = 16'h0BAD; tb_oe = 1; cas_n = 0;
      tick(); tick();
      cas_n = 1; we_n = 1; tb_oe = 0; tick();
      ram_read(0, 5, 1, fill(0, 5), "R9");
      ram_read(1, 5, 1, fill(1, 5), "R9");

      cur_req = "R7";
      transfer(0, 10, 0);
      stream(3, 0, 10, "R3");
      rst_n = 0; tick();
      chk(sq === '0, "R7", sq, '0);
      chk(dq === PULLED, "R7", dq, PULLED);
      rst_n = 1; tick();
      stream(3, 0, 0, "R7");

      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         done = 1;
         checks++; failures++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule